// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block sits behind a parallel memory-style bus with active-low select, write strobe and read strobe, and turns the bytes written on it into the behaviour of a flash part's command layer. The bus is sampled in the system clock domain. A write cycle is recognised when it ends, and the byte it carried is then interpreted as a command. Commands choose what a read returns: array data, an 8-bit status word, or a pair of identification bytes. They also start two-cycle program and block-erase sequences.

Operations run on a small timed engine. The engine holds a busy flag for a programmable number of clock cycles and then either issues a one-cycle commit pulse, carrying the operation's address, data and kind, to the array side or records a failure. A failure comes from a fault input, a low-supply input, or a write to the guarded block while the guard is closed. An active-low power-down input clears the status, aborts the engine and stops the read drive.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A byte is taken as a command only when select and write strobe are both low while the read strobe is high. It is acted on after the write strobe or select rises. A cycle with the read strobe low is ignored.
- R2: Command FFh selects array reads, which return `arr_rdata` for the presented address. Command 70h selects status reads. Command 90h selects identification reads: address bit 0 low returns MFR_CODE and address bit 0 high returns DEV_CODE. After reset the block is in array mode.
- R3: The status byte is laid out as follows. Bit 7 is ready (1 when the engine is idle). Bit 6 is always 0. Bit 5 is the erase error. Bit 4 is the write error. Bit 3 is supply low. Bits 2:0 are 0.
- R4: Command 10h or 40h arms a program, and the next write supplies the address and data. The engine is busy for `op_cycles` cycles and then pulses `commit_vld` once with that address and data and with `commit_erase` = 0.
- R5: Command 20h followed by D0h starts a block erase. The confirm write's address is reported on `commit_addr` with `commit_erase` = 1.
- R6: A setup or a started operation switches reads to status mode. Any read while busy returns status. Array data returns only after FFh.
- R7: While the engine is busy, every command except 70h is ignored.
- R8: Any byte other than D0h after 20h aborts the erase, sets bits 5 and 4, and starts nothing.
- R9: A program or erase whose top BLK_W address bits equal PROT_BLK, issued while `guard_open` is low, does not run. It sets bit 4 for a program or bit 5 for an erase. With `guard_open` high it runs normally.
- R10: If `supply_ok` is low when an operation would start, nothing runs. Bit 3 is set, together with the operation's error bit.
- R11: If `fault_inj` is high in the completion cycle, no commit is issued and the operation's error bit is set.
- R12: Error bits stay set until command 50h (given while idle) or power-down.
- R13: While `sleep_n` is low, `rd_oe` is 0 and the engine is aborted with no commit. Afterwards the status errors are clear and the read mode is array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n | input | 1 | Active-low power-down and abort |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_wstb_n | input | 1 | Write strobe, active low |
| bus_rstb_n | input | 1 | Read strobe, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data / command byte |
| guard_open | input | 1 | Permits operations on the guarded block |
| supply_ok | input | 1 | Operation supply present |
| fault_inj | input | 1 | Forces a failure at completion |
| op_cycles | input | CNT_W | Engine busy time in cycles (0 treated as 1) |
| arr_addr | output | ADDR_W | Sampled address to the array read port |
| arr_rdata | input | 8 | Array read data |
| rd_data | output | 8 | Read data |
| rd_oe | output | 1 | Read drive enable (0 = high impedance) |
| commit_vld | output | 1 | One-cycle pulse on successful completion |
| commit_erase | output | 1 | Completed operation was an erase |
| commit_addr | output | ADDR_W | Program address or erase confirm address |
| commit_data | output | 8 | Program data |

## Verification
Power-down and engine completion can land on the same clock edge. When they do, the block must either have committed before the power-down edge or not commit at all. The bench starts a program and then drops `sleep_n` at a sweep of offsets around the completion edge. For each offset it computes from `op_cycles` whether the completion edge came first, and compares the number of commit pulses with that expectation. A monitor also flags any commit pulse produced on an edge that saw `sleep_n` low.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rmode_t;
  typedef enum logic [1:0] {CS_IDLE, CS_PROG_ARM, CS_ERASE_ARM} cstate_t;

  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
endpackage

// File: rtl/fci_bus_capture.sv
module fci_bus_capture #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_n,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic              rstb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] s_addr,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [7:0]        evt_data,
  output logic              rd_act
);
  logic       sel_q, wstb_q, rstb_q, wact_d;
  logic [7:0] s_data;
  logic       wact;

  assign wact   = !sel_q && !wstb_q && rstb_q;
  assign wr_evt = wact_d && !wact;
  assign rd_act = !sel_q && !rstb_q && wstb_q;

  always_ff @(posedge clk) begin
    if (rst || !sleep_n) begin
      sel_q    <= 1'b1;
      wstb_q   <= 1'b1;
      rstb_q   <= 1'b1;
      wact_d   <= 1'b0;
      s_addr   <= '0;
      s_data   <= '0;
      evt_addr <= '0;
      evt_data <= '0;
    end else begin
      sel_q  <= sel_n;
      wstb_q <= wstb_n;
      rstb_q <= rstb_n;
      s_addr <= addr;
      s_data <= wdata;
      wact_d <= wact;
      if (wact) begin
        evt_addr <= s_addr;
        evt_data <= s_data;
      end
    end
  end
endmodule

// File: rtl/fci_engine.sv
module fci_engine #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_n,
  input  logic              start,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_data,
  input  logic [CNT_W-1:0]  op_cycles,
  input  logic              fault_inj,
  output logic              busy,
  output logic              done,
  output logic              op_erase,
  output logic              commit_vld,
  output logic              commit_erase,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [7:0]        commit_data
);
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;

  assign done = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !sleep_n) begin
      busy         <= 1'b0;
      cnt          <= '0;
      op_erase     <= 1'b0;
      op_addr      <= '0;
      op_data      <= '0;
      commit_vld   <= 1'b0;
      commit_erase <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
    end else begin
      commit_vld <= done && !fault_inj;
      if (done) begin
        commit_erase <= op_erase;
        commit_addr  <= op_addr;
        commit_data  <= op_data;
      end
      if (start) begin
        busy     <= 1'b1;
        cnt      <= (op_cycles == '0) ? CNT_W'(1) : op_cycles;
        op_erase <= start_erase;
        op_addr  <= start_addr;
        op_data  <= start_data;
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fci_cmd_ctrl.sv
module fci_cmd_ctrl
  import fci_pkg::*;
#(
  parameter int                BLK_W    = 2,
  parameter logic [BLK_W-1:0]  PROT_BLK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_n,
  input  logic             wr_evt,
  input  logic [BLK_W-1:0] evt_blk,
  input  logic [7:0]       evt_data,
  input  logic             busy,
  input  logic             eng_done,
  input  logic             eng_fail,
  input  logic             eng_erase,
  input  logic             guard_open,
  input  logic             supply_ok,
  output rmode_t           mode,
  output logic             start,
  output logic             start_erase,
  output logic             err_erase,
  output logic             err_write,
  output logic             err_supply
);
  cstate_t cst;
  logic take, go_prog, go_erase, bad_conf, locked, deny;

  always_comb begin
    take        = wr_evt && !busy;
    locked      = (evt_blk == PROT_BLK) && !guard_open;
    go_prog     = take && (cst == CS_PROG_ARM);
    go_erase    = take && (cst == CS_ERASE_ARM) && (evt_data == OP_CONFIRM);
    bad_conf    = take && (cst == CS_ERASE_ARM) && (evt_data != OP_CONFIRM);
    deny        = (go_prog || go_erase) && (locked || !supply_ok);
    start       = (go_prog || go_erase) && !deny;
    start_erase = go_erase;
  end

  always_ff @(posedge clk) begin
    if (rst || !sleep_n) begin
      cst        <= CS_IDLE;
      mode       <= RM_ARRAY;
      err_erase  <= 1'b0;
      err_write  <= 1'b0;
      err_supply <= 1'b0;
    end else begin
      if (eng_done && eng_fail) begin
        if (eng_erase) err_erase <= 1'b1;
        else           err_write <= 1'b1;
      end
      if (wr_evt && busy && (evt_data == OP_STATUS)) mode <= RM_STATUS;
      if (take) begin
        unique case (cst)
          CS_PROG_ARM, CS_ERASE_ARM: begin
            cst  <= CS_IDLE;
            mode <= RM_STATUS;
            if (bad_conf) begin
              err_erase <= 1'b1;
              err_write <= 1'b1;
            end
            if (deny) begin
              if (!supply_ok) err_supply <= 1'b1;
              if (go_erase) err_erase <= 1'b1;
              else          err_write <= 1'b1;
            end
          end
          default: begin
            unique case (evt_data)
              OP_ARRAY:  mode <= RM_ARRAY;
              OP_STATUS: mode <= RM_STATUS;
              OP_IDENT:  mode <= RM_IDENT;
              OP_CLEAR: begin
                err_erase  <= 1'b0;
                err_write  <= 1'b0;
                err_supply <= 1'b0;
              end
              OP_ERASE: begin
                cst  <= CS_ERASE_ARM;
                mode <= RM_STATUS;
              end
              OP_PROG_A, OP_PROG_B: begin
                cst  <= CS_PROG_ARM;
                mode <= RM_STATUS;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fci_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               BLK_W    = 2,
  parameter int               CNT_W    = 8,
  parameter logic [BLK_W-1:0] PROT_BLK = '1,
  parameter logic [7:0]       MFR_CODE = 8'hA5,
  parameter logic [7:0]       DEV_CODE = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_n,
  input  logic              bus_sel_n,
  input  logic              bus_wstb_n,
  input  logic              bus_rstb_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              guard_open,
  input  logic              supply_ok,
  input  logic              fault_inj,
  input  logic [CNT_W-1:0]  op_cycles,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        rd_data,
  output logic              rd_oe,
  output logic              commit_vld,
  output logic              commit_erase,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [7:0]        commit_data
);
  localparam int BLK_LSB = ADDR_W - BLK_W;

  logic [ADDR_W-1:0] s_addr, evt_addr;
  logic [7:0]        evt_data, status, rd_next;
  logic              wr_evt, rd_act;
  logic              eng_busy, eng_done, eng_erase;
  logic              op_start, op_start_erase;
  logic              err_erase, err_write, err_supply;
  rmode_t            rd_mode, eff_mode;

  fci_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .sleep_n(sleep_n),
    .sel_n(bus_sel_n), .wstb_n(bus_wstb_n), .rstb_n(bus_rstb_n),
    .addr(bus_addr), .wdata(bus_wdata),
    .s_addr(s_addr), .wr_evt(wr_evt),
    .evt_addr(evt_addr), .evt_data(evt_data), .rd_act(rd_act)
  );

  fci_cmd_ctrl #(.BLK_W(BLK_W), .PROT_BLK(PROT_BLK)) u_ctrl (
    .clk(clk), .rst(rst), .sleep_n(sleep_n),
    .wr_evt(wr_evt), .evt_blk(evt_addr[ADDR_W-1:BLK_LSB]), .evt_data(evt_data),
    .busy(eng_busy), .eng_done(eng_done), .eng_fail(fault_inj), .eng_erase(eng_erase),
    .guard_open(guard_open), .supply_ok(supply_ok),
    .mode(rd_mode), .start(op_start), .start_erase(op_start_erase),
    .err_erase(err_erase), .err_write(err_write), .err_supply(err_supply)
  );

  fci_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .sleep_n(sleep_n),
    .start(op_start), .start_erase(op_start_erase),
    .start_addr(evt_addr), .start_data(evt_data),
    .op_cycles(op_cycles), .fault_inj(fault_inj),
    .busy(eng_busy), .done(eng_done), .op_erase(eng_erase),
    .commit_vld(commit_vld), .commit_erase(commit_erase),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  assign arr_addr = s_addr;
  assign status   = {!eng_busy, 1'b0, err_erase, err_write, err_supply, 3'b000};

  always_comb begin
    eff_mode = eng_busy ? RM_STATUS : rd_mode;
    unique case (eff_mode)
      RM_STATUS: rd_next = status;
      RM_IDENT:  rd_next = s_addr[0] ? DEV_CODE : MFR_CODE;
      default:   rd_next = arr_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !sleep_n) begin
      rd_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_oe   <= rd_act;
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/fci_checker.sv
module fci_checker (
  input logic       clk,
  input logic       rst,
  input logic       sleep_n,
  input logic       busy,
  input logic       start,
  input logic       wr_evt,
  input logic [7:0] evt_data,
  input logic [1:0] mode,
  input logic [2:0] err_bits,
  input logic       rd_oe,
  input logic       commit_vld
);
  localparam logic [1:0] M_ARRAY  = 2'd0;
  localparam logic [1:0] M_STATUS = 2'd1;

  // R7: the engine is never restarted while it runs
  p_start_idle_r7: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R7: commands other than status read leave the read mode alone while busy
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (sleep_n && busy && wr_evt && evt_data != 8'h70) |=> $stable(mode));

  // R6: a started operation leaves the read path in status mode
  p_start_status_r6: assert property (@(posedge clk) disable iff (rst)
    (sleep_n && start) |=> (mode == M_STATUS));

  // R4: a commit pulse only follows a busy engine
  p_commit_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> $past(busy));

  // R13: power-down silences the outputs and aborts the engine
  p_pd_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !sleep_n |=> (!rd_oe && !commit_vld && !busy && mode == M_ARRAY && err_bits == 3'b000));

  // R12: error bits are not cleared without the clear command or power-down
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (sleep_n && !(wr_evt && !busy && evt_data == 8'h50))
      |=> ((err_bits & $past(err_bits)) == $past(err_bits)));
endmodule

bind flash_cmd_fsm fci_checker u_chk (
  .clk(clk), .rst(rst), .sleep_n(sleep_n), .busy(eng_busy), .start(op_start),
  .wr_evt(wr_evt), .evt_data(evt_data), .mode(rd_mode),
  .err_bits({err_erase, err_write, err_supply}), .rd_oe(rd_oe), .commit_vld(commit_vld)
);

// File: tb/tb_flash_cmd_fsm.sv
module tb_flash_cmd_fsm;
  localparam int N = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_n = 1'b1;
  logic       sel_n = 1'b1, wstb_n = 1'b1, rstb_n = 1'b1;
  logic [7:0] addr = '0, wdata = '0;
  logic       guard_open = 1'b0, supply_ok = 1'b1, fault_inj = 1'b0;
  logic [7:0] op_cycles = 8'(N);
  logic [7:0] arr_addr, arr_rdata, rd_data, commit_addr, commit_data;
  logic       rd_oe, commit_vld, commit_erase;

  int nchk = 0, nfail = 0, ncommit = 0;
  logic [7:0] last_addr, last_data;
  logic       last_erase, sleep_seen = 1'b1, finished = 1'b0;
  logic [7:0] rdv;
  logic       roe;

  always #2 clk = ~clk;

  assign arr_rdata = arr_addr ^ 8'h5A;

  flash_cmd_fsm dut (
    .clk(clk), .rst(rst), .sleep_n(sleep_n),
    .bus_sel_n(sel_n), .bus_wstb_n(wstb_n), .bus_rstb_n(rstb_n),
    .bus_addr(addr), .bus_wdata(wdata),
    .guard_open(guard_open), .supply_ok(supply_ok), .fault_inj(fault_inj),
    .op_cycles(op_cycles), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .rd_oe(rd_oe),
    .commit_vld(commit_vld), .commit_erase(commit_erase),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) sleep_seen = sleep_n;

  always @(negedge clk) begin
    if (commit_vld) begin
      ncommit++;
      last_addr  = commit_addr;
      last_data  = commit_data;
      last_erase = commit_erase;
      if (!sleep_seen) check("R13 commit during power-down", 1, 0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic rs = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; sel_n = 1'b0; wstb_n = 1'b0; rstb_n = rs;
    @(negedge clk);
    @(negedge clk);
    sel_n = 1'b1; wstb_n = 1'b1; rstb_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    addr = a; sel_n = 1'b0; rstb_n = 1'b0; wstb_n = 1'b1;
    repeat (3) @(negedge clk);
    rdv = rd_data; roe = rd_oe;
    sel_n = 1'b1; rstb_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (N + 6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R13 rd_oe idle after reset", {31'd0, rd_oe}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2: array mode after reset
    rd(8'h12);
    check("R2 reset array oe", {31'd0, roe}, 1);
    check("R2 reset array data", rdv, 8'h12 ^ 8'h5A);
    wr(8'h00, 8'h70);
    rd(8'h00);
    check("R3 idle status", rdv, 8'h80);

    // R1: write with read strobe low is ignored, select high is ignored
    wr(8'h00, 8'hFF, 1'b0);
    rd(8'h33);
    check("R1 read strobe low write ignored", rdv, 8'h80);
    @(negedge clk); addr = 8'h33; wdata = 8'hFF; wstb_n = 1'b0;
    repeat (3) @(negedge clk); wstb_n = 1'b1; repeat (3) @(negedge clk);
    rd(8'h33);
    check("R1 no select write ignored", rdv, 8'h80);

    // R2: identification and back to array
    wr(8'h00, 8'h90);
    rd(8'h00); check("R2 ident low", rdv, 8'hA5);
    rd(8'h41); check("R2 ident high", rdv, 8'h3C);
    wr(8'h00, 8'hFF);
    rd(8'h34); check("R2 array again", rdv, 8'h34 ^ 8'h5A);

    // R4 / R6: program sweep
    for (int i = 0; i < 8; i++) begin
      automatic logic [7:0] a = 8'(i * 23 + 1);
      automatic logic [7:0] d = 8'(i * 37 + 9);
      automatic int c0 = ncommit;
      wr(8'h00, (i % 2 == 0) ? 8'h40 : 8'h10);
      wr(a, d);
      rd(a); check("R6 busy read gives status", rdv, 8'h00);
      settle();
      check("R4 one commit", ncommit - c0, 1);
      check("R4 commit addr", last_addr, a);
      check("R4 commit data", last_data, d);
      check("R4 commit kind", {31'd0, last_erase}, 0);
      rd(a); check("R6 status mode after program", rdv, 8'h80);
      wr(8'h00, 8'hFF);
      rd(a); check("R6 array after FF", rdv, a ^ 8'h5A);
    end

    // R5: erase per unguarded block
    for (int b = 0; b < 3; b++) begin
      automatic logic [7:0] a = 8'((b << 6) | 5);
      automatic int c0 = ncommit;
      wr(8'h00, 8'h20);
      wr(a, 8'hD0);
      settle();
      check("R5 one commit", ncommit - c0, 1);
      check("R5 erase addr", last_addr, a);
      check("R5 erase kind", {31'd0, last_erase}, 1);
    end

    // R7: commands ignored while busy
    wr(8'h00, 8'h40);
    wr(8'h22, 8'h66);
    wr(8'h00, 8'hFF);
    rd(8'h22); check("R7 FF ignored while busy", rdv, 8'h00);
    settle();
    rd(8'h22); check("R7 mode still status", rdv, 8'h80);

    // R8 / R12: aborted erase, sticky errors, clear
    begin
      automatic int c0 = ncommit;
      wr(8'h00, 8'h20);
      wr(8'h10, 8'h77);
      rd(8'h00); check("R8 abort status", rdv, 8'hB0);
      settle();
      check("R8 abort no commit", ncommit - c0, 0);
    end
    wr(8'h00, 8'hFF);
    rd(8'h05); check("R12 array readable with errors", rdv, 8'h05 ^ 8'h5A);
    wr(8'h00, 8'h70);
    rd(8'h00); check("R12 errors sticky", rdv, 8'hB0);
    wr(8'h00, 8'h50);
    rd(8'h00); check("R12 clear", rdv, 8'h80);

    // R9: guarded block
    begin
      automatic int c0 = ncommit;
      wr(8'h00, 8'h40); wr(8'hC5, 8'h11);
      rd(8'h00); check("R9 guarded program denied", rdv, 8'h90);
      wr(8'h00, 8'h50);
      wr(8'h00, 8'h20); wr(8'hC0, 8'hD0);
      rd(8'h00); check("R9 guarded erase denied", rdv, 8'hA0);
      wr(8'h00, 8'h50);
      settle();
      check("R9 denied no commit", ncommit - c0, 0);
      guard_open = 1'b1;
      wr(8'h00, 8'h40); wr(8'hC5, 8'h11);
      settle();
      check("R9 guard open commit", ncommit - c0, 1);
      check("R9 guard open addr", last_addr, 8'hC5);
      guard_open = 1'b0;
    end

    // R10: supply low
    supply_ok = 1'b0;
    wr(8'h00, 8'h10); wr(8'h08, 8'h01);
    rd(8'h00); check("R10 program supply low", rdv, 8'h98);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h20); wr(8'h48, 8'hD0);
    rd(8'h00); check("R10 erase supply low", rdv, 8'hA8);
    wr(8'h00, 8'h50);
    supply_ok = 1'b1;

    // R11: injected fault
    begin
      automatic int c0 = ncommit;
      fault_inj = 1'b1;
      wr(8'h00, 8'h40); wr(8'h09, 8'h02);
      settle();
      fault_inj = 1'b0;
      rd(8'h00); check("R11 fault status", rdv, 8'h90);
      check("R11 fault no commit", ncommit - c0, 0);
      wr(8'h00, 8'h50);
    end

    // R13: rd_oe off while powered down
    sleep_n = 1'b0;
    @(negedge clk); addr = 8'h01; sel_n = 1'b0; rstb_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 no drive while down", {31'd0, rd_oe}, 0);
    sel_n = 1'b1; rstb_n = 1'b1; sleep_n = 1'b1;
    repeat (2) @(negedge clk);

    // R13: power-down swept across the completion edge
    for (int k = N - 5; k <= N + 2; k++) begin
      automatic int c0 = ncommit;
      wr(8'h00, 8'h20); wr(8'h10, 8'h55);   // leave error bits set
      wr(8'h00, 8'h40); wr(8'h0C, 8'hAB);
      repeat (k) @(negedge clk);
      sleep_n = 1'b0;
      repeat (2) @(negedge clk);
      sleep_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R13 commit vs power-down order", ncommit - c0, (k >= N - 1) ? 1 : 0);
      rd(8'h0C); check("R13 array mode after down", rdv, 8'h0C ^ 8'h5A);
      wr(8'h00, 8'h70);
      rd(8'h00); check("R13 status cleared", rdv, 8'h80);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule